// File: doc/BRIEF.md
# Twinax Biphase Frame Receiver

This block recovers messages from a sampled two-level biphase line. The line is sampled once per clock at eight samples per bit cell. The block measures the length of each constant-level run. It waits for a frame-sync code violation, then decodes the bit stream into 16-bit frames. It skips the zero fill bits between frames, checks each frame's parity and selects messages by station address. Each accepted frame is presented as a data byte, a 3-bit address and status flags on a valid/ready output.

A message opens with a run of one-bits, followed by the violation: an over-long high level and then an over-long low level. The first frame decides whether this station takes part in the message. The first frame with address 7 ends the message, and the receiver then goes back to waiting for the next violation. A broken bit cell aborts the message and raises an error pulse. Frames beyond the frame limit are dropped and raise an overflow pulse.

Top module: `twx_rx`

## Requirements
- R1: Frames are decoded only after frame sync. Frame sync is a high run of 10 to 14 samples followed at once by a low run of 10 to 14 samples. A stream of one-bits with no such violation produces no frames and no errors.
- R2: Between frames, any number of 0 bits is skipped. A frame begins at the next bit of value 1, and that start bit is part of the frame.
- R3: Bit coding: a 1 is high then low within its cell, and a 0 is low then high. Each half lasts 4 samples. After the start bit come 8 data bits (least significant first), 3 address bits (least significant first) and one parity bit. A frame is still delivered when the count of ones over start, data, address and parity is odd, but with `frm_perr_o` set.
- R4: The first frame after frame sync selects this station only if its address equals `my_addr_i`. A message whose first frame carries another address delivers no frames.
- R5: Once selected, the station receives every later frame of the message whatever its address. A frame with address 7 is delivered with `frm_eom_o` set and ends the message.
- R6: A message delivers at most 256 frames. Each further frame is dropped and raises a one-cycle `ovf_o` pulse.
- R7: While a message is open, a one-cycle `code_err_o` pulse aborts the message. The causes are a missing mid-bit transition (a run longer than 9 samples), a run class that is wrong for the bit phase, or a run shorter than 2 samples. After an error, only a new frame sync opens a message.
- R8: `frm_valid_o` stays high with its fields held until `frm_rdy_i` is seen high. A frame that completes while an earlier one is still held replaces it.
- R9: Half-bit runs of 3 to 5 samples and full-bit runs of 6 to 9 samples are decoded correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, eight per bit cell |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Sliced line level, one sample per clock |
| my_addr_i | input | 3 | This station's address (0 to 6) |
| frm_rdy_i | input | 1 | Consumer accepts the held frame |
| frm_valid_o | output | 1 | A frame is held on the outputs |
| frm_data_o | output | 8 | Data byte of the frame |
| frm_addr_o | output | 3 | Address field of the frame |
| frm_eom_o | output | 1 | Frame carries the end-of-message address |
| frm_perr_o | output | 1 | Frame failed the even-parity check |
| ovf_o | output | 1 | Pulse: a frame past the limit was dropped |
| code_err_o | output | 1 | Pulse: a biphase coding error aborted the message |

## Verification
The assertions check four things on every cycle. A frame only appears while a message is open. A held frame stays valid until it is accepted. The frame count never passes its limit, and an overflow pulse never comes with a new frame. A coding error is a single pulse that closes the message. Everything that depends on the serial content can only be shown by the bench scenarios. That covers bit order, parity flags, address selection and its persistence, end-of-message handling, fill skipping, timing jitter, the 257th frame and recovery after an aborted message.

// File: rtl/twx_pkg.sv
package twx_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] EOM_ADDR = 3'd7;

  typedef enum logic [1:0] {RUN_BAD, RUN_SHORT, RUN_LONG, RUN_VIOL} run_cls_e;
  typedef enum logic [1:0] {DS_HUNT, DS_BND, DS_MID} dec_st_e;
  typedef enum logic [1:0] {FS_IDLE, FS_WAIT, FS_BITS} frm_st_e;
endpackage

// File: rtl/twx_runlen.sv
module twx_runlen
  import twx_pkg::*;
#(
  parameter int OVS = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     line_i,
  output logic     edge_o,
  output logic     lvl_o,
  output run_cls_e cls_o,
  output logic     stall_o
);
  localparam int HALF   = OVS / 2;
  localparam int SH_MIN = HALF / 2;
  localparam int SH_MAX = HALF + HALF / 4;
  localparam int LG_MAX = 2 * HALF + HALF / 4;
  localparam int VI_MAX = 3 * HALF + HALF / 2;
  localparam int RLW    = $clog2(VI_MAX + 2);
  localparam logic [RLW-1:0] C_SHMIN = RLW'(SH_MIN);
  localparam logic [RLW-1:0] C_SHMAX = RLW'(SH_MAX);
  localparam logic [RLW-1:0] C_LGMAX = RLW'(LG_MAX);
  localparam logic [RLW-1:0] C_VIMAX = RLW'(VI_MAX);

  logic           lvl_q;
  logic [RLW-1:0] rl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      rl_q  <= '0;
    end else begin
      lvl_q <= line_i;
      if (line_i != lvl_q) rl_q <= RLW'(1);
      else if (rl_q != '1) rl_q <= rl_q + RLW'(1);
    end
  end

  assign edge_o  = (line_i != lvl_q);
  assign lvl_o   = lvl_q;
  assign stall_o = (rl_q > C_LGMAX);

  always_comb begin
    if (rl_q >= C_SHMIN && rl_q <= C_SHMAX)      cls_o = RUN_SHORT;
    else if (rl_q > C_SHMAX && rl_q <= C_LGMAX)  cls_o = RUN_LONG;
    else if (rl_q > C_LGMAX && rl_q <= C_VIMAX)  cls_o = RUN_VIOL;
    else                                         cls_o = RUN_BAD;
  end
endmodule

// File: rtl/twx_bitdec.sv
module twx_bitdec
  import twx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     edge_i,
  input  logic     lvl_i,
  input  run_cls_e cls_i,
  input  logic     stall_i,
  input  logic     end_i,
  output logic     bit_v_o,
  output logic     bit_o,
  output logic     sync_o,
  output logic     cerr_o
);
  dec_st_e st_q;
  logic    vh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= DS_HUNT;
      vh_q    <= 1'b0;
      bit_v_o <= 1'b0;
      bit_o   <= 1'b0;
      sync_o  <= 1'b0;
      cerr_o  <= 1'b0;
    end else begin
      bit_v_o <= 1'b0;
      sync_o  <= 1'b0;
      cerr_o  <= 1'b0;
      if (end_i) begin
        st_q <= DS_HUNT;
        vh_q <= 1'b0;
      end else begin
        case (st_q)
          DS_HUNT: if (edge_i) begin
            if (cls_i == RUN_VIOL && lvl_i) vh_q <= 1'b1;
            else if (cls_i == RUN_VIOL && !lvl_i && vh_q) begin
              vh_q   <= 1'b0;
              st_q   <= DS_BND;
              sync_o <= 1'b1;
            end else vh_q <= 1'b0;
          end
          DS_BND: begin
            if (edge_i) begin
              if (cls_i == RUN_SHORT) begin
                bit_v_o <= 1'b1;
                bit_o   <= lvl_i;
                st_q    <= DS_MID;
              end else begin
                cerr_o <= 1'b1;
                st_q   <= DS_HUNT;
              end
            end else if (stall_i) begin
              cerr_o <= 1'b1;
              st_q   <= DS_HUNT;
            end
          end
          DS_MID: begin
            if (edge_i) begin
              if (cls_i == RUN_SHORT) st_q <= DS_BND;
              else if (cls_i == RUN_LONG) begin
                bit_v_o <= 1'b1;
                bit_o   <= lvl_i;
              end else begin
                cerr_o <= 1'b1;
                st_q   <= DS_HUNT;
              end
            end else if (stall_i) begin
              cerr_o <= 1'b1;
              st_q   <= DS_HUNT;
            end
          end
          default: st_q <= DS_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/twx_frame.sv
module twx_frame
  import twx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int MAX_FRAMES = 256,
  localparam int CNTW      = $clog2(MAX_FRAMES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_i,
  input  logic              bit_v_i,
  input  logic              bit_i,
  input  logic              cerr_i,
  input  logic [ADDR_W-1:0] my_addr_i,
  input  logic              rdy_i,
  output logic              end_o,
  output logic              fv_o,
  output logic [DATA_W-1:0] fdata_o,
  output logic [ADDR_W-1:0] faddr_o,
  output logic              feom_o,
  output logic              fperr_o,
  output logic              ovf_o,
  output logic              cerr_o,
  output logic [CNTW-1:0]   cnt_o,
  output logic              act_o
);
  localparam int FLEN = DATA_W + ADDR_W + 1;
  localparam int BCW  = $clog2(FLEN + 1);

  frm_st_e           st_q;
  logic [FLEN-2:0]   sr_q;
  logic [FLEN-1:0]   full;
  logic [BCW-1:0]    bc_q;
  logic [CNTW-1:0]   cnt_q;
  logic              sel_q;

  logic [DATA_W-1:0] w_data;
  logic [ADDR_W-1:0] w_addr;
  logic              w_perr, w_last, w_sel, w_eom, w_cap;

  assign full   = {bit_i, sr_q};
  assign w_data = full[DATA_W-1:0];
  assign w_addr = full[DATA_W +: ADDR_W];
  assign w_perr = ~(^full);
  assign w_last = (bc_q == BCW'(FLEN - 1));
  assign w_sel  = (cnt_q == '0) ? (w_addr == my_addr_i) : sel_q;
  assign w_eom  = (w_addr == EOM_ADDR);
  assign w_cap  = (cnt_q == CNTW'(MAX_FRAMES));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= FS_IDLE;
      sr_q    <= '0;
      bc_q    <= '0;
      cnt_q   <= '0;
      sel_q   <= 1'b0;
      end_o   <= 1'b0;
      fv_o    <= 1'b0;
      fdata_o <= '0;
      faddr_o <= '0;
      feom_o  <= 1'b0;
      fperr_o <= 1'b0;
      ovf_o   <= 1'b0;
      cerr_o  <= 1'b0;
    end else begin
      end_o  <= 1'b0;
      ovf_o  <= 1'b0;
      cerr_o <= 1'b0;
      if (fv_o && rdy_i) fv_o <= 1'b0;
      if (cerr_i) begin
        cerr_o <= 1'b1;
        st_q   <= FS_IDLE;
      end else begin
        case (st_q)
          FS_IDLE: if (sync_i) begin
            st_q  <= FS_WAIT;
            cnt_q <= '0;
            sel_q <= 1'b0;
          end
          FS_WAIT: if (bit_v_i && bit_i) begin
            st_q <= FS_BITS;
            bc_q <= '0;
          end
          FS_BITS: if (bit_v_i) begin
            sr_q <= full[FLEN-1:1];
            bc_q <= bc_q + BCW'(1);
            if (w_last) begin
              st_q  <= w_eom ? FS_IDLE : FS_WAIT;
              end_o <= w_eom;
              if (w_cap) ovf_o <= 1'b1;
              else begin
                cnt_q <= cnt_q + CNTW'(1);
                sel_q <= w_sel;
                if (w_sel) begin
                  fv_o    <= 1'b1;
                  fdata_o <= w_data;
                  faddr_o <= w_addr;
                  feom_o  <= w_eom;
                  fperr_o <= w_perr;
                end
              end
            end
          end
          default: st_q <= FS_IDLE;
        endcase
      end
    end
  end

  assign cnt_o = cnt_q;
  assign act_o = (st_q != FS_IDLE);
endmodule

// File: rtl/twx_rx.sv
module twx_rx
  import twx_pkg::*;
#(
  parameter int OVS        = 8,
  parameter int DATA_W     = 8,
  parameter int MAX_FRAMES = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_i,
  input  logic [2:0]        my_addr_i,
  input  logic              frm_rdy_i,
  output logic              frm_valid_o,
  output logic [DATA_W-1:0] frm_data_o,
  output logic [2:0]        frm_addr_o,
  output logic              frm_eom_o,
  output logic              frm_perr_o,
  output logic              ovf_o,
  output logic              code_err_o
);
  localparam int CNTW = $clog2(MAX_FRAMES + 1);

  logic            rl_edge, rl_lvl, rl_stall;
  run_cls_e        rl_cls;
  logic            dec_bv, dec_bit, dec_sync, dec_cerr;
  logic            frm_end, frm_act;
  logic [CNTW-1:0] frm_cnt;

  twx_runlen #(.OVS(OVS)) u_rl (
    .clk(clk), .rst(rst), .line_i(line_i),
    .edge_o(rl_edge), .lvl_o(rl_lvl), .cls_o(rl_cls), .stall_o(rl_stall)
  );

  twx_bitdec u_dec (
    .clk(clk), .rst(rst), .edge_i(rl_edge), .lvl_i(rl_lvl), .cls_i(rl_cls),
    .stall_i(rl_stall), .end_i(frm_end),
    .bit_v_o(dec_bv), .bit_o(dec_bit), .sync_o(dec_sync), .cerr_o(dec_cerr)
  );

  twx_frame #(.DATA_W(DATA_W), .MAX_FRAMES(MAX_FRAMES)) u_frm (
    .clk(clk), .rst(rst), .sync_i(dec_sync), .bit_v_i(dec_bv), .bit_i(dec_bit),
    .cerr_i(dec_cerr), .my_addr_i(my_addr_i), .rdy_i(frm_rdy_i),
    .end_o(frm_end), .fv_o(frm_valid_o), .fdata_o(frm_data_o),
    .faddr_o(frm_addr_o), .feom_o(frm_eom_o), .fperr_o(frm_perr_o),
    .ovf_o(ovf_o), .cerr_o(code_err_o), .cnt_o(frm_cnt), .act_o(frm_act)
  );
endmodule

// File: rtl/twx_rx_chk.sv
module twx_rx_chk #(
  parameter int MAX_FRAMES = 256,
  localparam int CNTW      = $clog2(MAX_FRAMES + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            valid_i,
  input logic            rdy_i,
  input logic            ovf_i,
  input logic            cerr_i,
  input logic            act_i,
  input logic [CNTW-1:0] cnt_i
);
  AST_FRAME_IN_MSG: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_i) |-> $past(act_i)); // R1
  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (rst)
    valid_i && !rdy_i |=> valid_i); // R8
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_i <= CNTW'(MAX_FRAMES)); // R6
  AST_OVF_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    ovf_i |-> cnt_i == CNTW'(MAX_FRAMES)); // R6
  AST_OVF_NO_FRAME: assert property (@(posedge clk) disable iff (rst)
    ovf_i |-> !$rose(valid_i)); // R6
  AST_CERR_PULSE: assert property (@(posedge clk) disable iff (rst)
    cerr_i |=> !cerr_i); // R7
  AST_CERR_CLOSES: assert property (@(posedge clk) disable iff (rst)
    cerr_i |-> !act_i); // R7
endmodule

bind twx_rx twx_rx_chk #(.MAX_FRAMES(MAX_FRAMES)) u_chk (
  .clk(clk), .rst(rst), .valid_i(frm_valid_o), .rdy_i(frm_rdy_i),
  .ovf_i(ovf_o), .cerr_i(code_err_o), .act_i(frm_act), .cnt_i(frm_cnt)
);

// File: tb/twx_rx_test.sv
`timescale 1ns/1ps
module twx_rx_test;
  localparam int MAXF = 256;
  localparam int NMAX = 300;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line = 1'b0;
  logic [2:0] my_addr = 3'd3;
  logic       rdy = 1'b1;
  logic       fv, feom, fperr, ovf, cerr;
  logic [7:0] fdata;
  logic [2:0] faddr;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0] md [NMAX];
  logic [2:0] ma [NMAX];
  bit         mb [NMAX];
  int         mn;

  logic [7:0] ed [NMAX];
  logic [2:0] ea [NMAX];
  bit         ee [NMAX];
  bit         ep [NMAX];
  int         en, eovf;

  logic [7:0] gd [NMAX];
  logic [2:0] ga [NMAX];
  bit         ge [NMAX];
  bit         gp [NMAX];
  int         gn = 0, govf = 0, gcerr = 0;

  always #5 clk = ~clk;

  twx_rx uut (
    .clk(clk), .rst(rst), .line_i(line), .my_addr_i(my_addr), .frm_rdy_i(rdy),
    .frm_valid_o(fv), .frm_data_o(fdata), .frm_addr_o(faddr), .frm_eom_o(feom),
    .frm_perr_o(fperr), .ovf_o(ovf), .code_err_o(cerr)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (fv && rdy && gn < NMAX) begin
        gd[gn] = fdata; ga[gn] = faddr; ge[gn] = feom; gp[gn] = fperr;
        gn = gn + 1;
      end
      if (ovf) govf = govf + 1;
      if (cerr) gcerr = gcerr + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  task automatic drive(input logic v, input int n);
    line = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input bit jit);
    int h1, h2;
    h1 = jit ? 3 + int'($urandom % 3) : 4;
    h2 = jit ? 3 + int'($urandom % 2) : 4;
    drive(b, h1);
    drive(~b, h2);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic [2:0] a, input bit badp,
                            input int fill, input bit jit);
    logic p;
    p = 1'b1 ^ (^d) ^ (^a) ^ badp;
    send_bit(1'b1, jit);
    for (int i = 0; i < 8; i++) send_bit(d[i], jit);
    for (int i = 0; i < 3; i++) send_bit(a[i], jit);
    send_bit(p, jit);
    for (int i = 0; i < fill; i++) send_bit(1'b0, jit);
  endtask

  task automatic send_msg(input bit with_sync, input bit jit, input int maxfill);
    drive(1'b0, 20);
    for (int i = 0; i < 5; i++) send_bit(1'b1, jit);
    if (with_sync) begin
      drive(1'b1, 12);
      drive(1'b0, 12);
    end
    for (int i = 0; i < mn; i++)
      send_frame(md[i], ma[i], mb[i], 3 + int'($urandom % (maxfill - 2)), jit);
    drive(1'b0, 40);
  endtask

  function automatic void model();
    bit s;
    s = 0; en = 0; eovf = 0;
    for (int i = 0; i < mn; i++) begin
      if (i >= MAXF) eovf++;
      else begin
        s = (i == 0) ? (ma[i] == my_addr) : s;
        if (s) begin
          ed[en] = md[i]; ea[en] = ma[i]; ee[en] = (ma[i] == 3'd7); ep[en] = mb[i];
          en++;
        end
      end
      if (ma[i] == 3'd7) break;
    end
  endfunction

  task automatic run_msg(input bit with_sync, input bit jit, input int maxfill);
    gn = 0; govf = 0; gcerr = 0;
    send_msg(with_sync, jit, maxfill);
    if (with_sync) model(); else begin en = 0; eovf = 0; end
    check(gn == en, "R4 R5 frame count", gn, en);
    for (int i = 0; i < en && i < gn; i++) begin
      check(gd[i] == ed[i], "R3 data byte", gd[i], ed[i]);
      check(ga[i] == ea[i], "R3 address", ga[i], ea[i]);
      check(ge[i] == ee[i], "R5 eom flag", ge[i], ee[i]);
      check(gp[i] == ep[i], "R3 parity flag", gp[i], ep[i]);
    end
    check(govf == eovf, "R6 overflow pulses", govf, eovf);
    check(gcerr == 0, "R7 no code error", gcerr, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(fv == 0, "R8 reset valid", fv, 0);
    check(ovf == 0, "R6 reset ovf", ovf, 0);
    check(cerr == 0, "R7 reset code error", cerr, 0);

    // R3 R5: directed message, bit order, parity flag, address changes
    mn = 3;
    md[0] = 8'hA5; ma[0] = 3'd3; mb[0] = 0;
    md[1] = 8'h3C; ma[1] = 3'd5; mb[1] = 1;
    md[2] = 8'h81; ma[2] = 3'd7; mb[2] = 0;
    run_msg(1, 0, 3);
    check(gd[0] == 8'hA5, "R3 first byte", gd[0], 8'hA5);
    check(gp[1] == 1, "R3 bad parity flagged", gp[1], 1);
    check(ga[1] == 3'd5, "R5 selection kept", ga[1], 5);
    check(ge[2] == 1, "R5 eom last frame", ge[2], 1);

    // R4: other station addressed
    md[0] = 8'h11; ma[0] = 3'd2;
    run_msg(1, 0, 3);
    check(gn == 0, "R4 not selected", gn, 0);

    // R1: preamble without violation
    md[0] = 8'h55; ma[0] = 3'd3; mb[0] = 0;
    run_msg(0, 0, 3);
    check(gn == 0, "R1 no sync no frames", gn, 0);

    // R2 R9: random messages with jitter and variable fill
    for (int k = 0; k < 24; k++) begin
      mn = 1 + int'($urandom % 6);
      for (int i = 0; i < mn; i++) begin
        md[i] = 8'($urandom);
        ma[i] = 3'($urandom % 7);
        mb[i] = ($urandom % 8) == 0;
      end
      if ($urandom % 2) ma[0] = my_addr;
      ma[mn-1] = 3'd7;
      run_msg(1, 1, 10);
    end

    // R7: missing transition mid frame, then recovery
    gn = 0; gcerr = 0;
    drive(1'b0, 20);
    for (int i = 0; i < 5; i++) send_bit(1'b1, 0);
    drive(1'b1, 12); drive(1'b0, 12);
    send_bit(1'b1, 0); send_bit(1'b0, 0); send_bit(1'b1, 0);
    drive(1'b1, 20);
    drive(1'b0, 40);
    check(gcerr == 1, "R7 code error pulse", gcerr, 1);
    check(gn == 0, "R7 aborted frame dropped", gn, 0);
    mn = 2;
    md[0] = 8'h42; ma[0] = 3'd3; mb[0] = 0;
    md[1] = 8'h99; ma[1] = 3'd7; mb[1] = 0;
    run_msg(1, 0, 3);

    // R8: held frame replaced while ready low
    rdy = 1'b0;
    gn = 0;
    md[0] = 8'h11; ma[0] = 3'd3;
    md[1] = 8'h22; ma[1] = 3'd7;
    send_msg(1, 0, 3);
    check(fv == 1, "R8 valid held", fv, 1);
    check(fdata == 8'h22, "R8 newest frame held", fdata, 8'h22);
    repeat (20) @(negedge clk);
    check(fv == 1 && fdata == 8'h22, "R8 still held", fdata, 8'h22);
    rdy = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(fv == 0, "R8 released", fv, 0);

    // R6: 257 frames, last one is the delimiter
    mn = MAXF + 1;
    for (int i = 0; i < mn; i++) begin
      md[i] = 8'(i); ma[i] = (i == mn - 1) ? 3'd7 : 3'd3; mb[i] = 0;
    end
    run_msg(1, 0, 3);
    check(gn == MAXF, "R6 frames kept", gn, MAXF);
    check(govf == 1, "R6 one overflow", govf, 1);

    report();
  end
endmodule